// File: doc/BRIEF.md
# SPI Flash Short-Command Engine

This block is an SPI master seen by the host as eight byte-wide registers. The host stores an opcode, up to three address bytes and one extra byte. It then writes a control byte to launch the command. The control byte picks one of two serial clock rates, sets how many bytes go out (1, 2, 4 or 5) and sets how many response bytes, from zero to three, are read back. While chip select stays low, the engine sends the outgoing bytes in wire order, most significant bit first, in SPI mode 0. It then clocks in the response bytes. Chip select returns high for one full SCK period before the busy flag drops.

The host polls the busy flag at offset 0 and then reads the response bytes at offsets 5 to 7. The address registers are stored in reverse: the first address byte on the wire sits at offset 4 and the last at offset 2. The register port has no back-pressure. Every write is taken in the cycle it is presented, and reads are combinational. The register port carries control only, so it uses no valid/ready handshake.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, offset 0 and every other offset read 0x00, chip select is high (spi_cs_n = 1), and SCK and MOSI are low.
- R2: Writes to offsets 1 to 4 are stored and read back unchanged. Offset 0 reads busy in bit 7 and zero in bits 6:0.
- R3: A control write (offset 0) starts a command only when busy is clear and bits 7:4 equal 0x4 or 0x5. Any other upper nibble leaves the engine idle. Busy and chip select change together on the clock edge after the write.
- R4: Control bits 1:0 set the outgoing byte count: code 0 sends 1 byte, code 1 sends 2, code 2 sends 4 and code 3 sends 5.
- R5: Wire order is the opcode (offset 1) first. A 2-byte command then sends the byte at offset 7. Commands of 4 or 5 bytes send the bytes at offsets 4, 3 and 2, in that order, and a 5-byte command then sends offset 7 last.
- R6: Control bits 3:2 give the response byte count, from 0 to 3. Response bytes appear at offsets 5, 6 and 7 in arrival order, and offsets whose byte was not read read 0x00.
- R7: An upper nibble of 0x5 runs SCK with half-periods of FAST_HALF system clocks. An upper nibble of 0x4 uses SLOW_HALF.
- R8: SPI mode 0, MSB first. After chip select falls, SCK stays low for one half-period. Each bit is then SCK high for a half-period followed by low for a half-period. MOSI changes only while SCK is low, and MOSI is 0 during response bytes.
- R9: Chip select stays low from the first bit through the last response bit. It is then high for two half-periods before busy clears, and SCK is never high while chip select is high.
- R10: A control write while busy is set is ignored and leaves the running command unchanged.
- R11: Data register writes during a command are stored but do not change the bytes being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A command's first output change is due on the clock edge after the control write. Busy then lasts H*(3 + 16*B) cycles, where H is the half-period and B is the sum of written and read bytes. A 5-byte, 3-read command at the fast rate therefore holds busy for 262 cycles. When a command is accepted, the bench reference model expands it into one expected {busy, cs_n, sck, mosi} entry per cycle. It pops one entry at every falling clock edge, so each output is checked in the exact cycle it is due. Register writes are visible on the read port one cycle after their edge, and response bytes are read only once the model's queue has drained.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int MAX_TX = 5;
  localparam int MAX_RX = 3;
  localparam int FRAME_W = MAX_TX * BYTE_W;
  localparam int RX_W = MAX_RX * BYTE_W;

  localparam logic [2:0] OFF_CTRL  = 3'd0;
  localparam logic [2:0] OFF_OP    = 3'd1;
  localparam logic [2:0] OFF_ADR_C = 3'd2;
  localparam logic [2:0] OFF_ADR_B = 3'd3;
  localparam logic [2:0] OFF_ADR_A = 3'd4;
  localparam logic [2:0] OFF_RSP0  = 3'd5;
  localparam logic [2:0] OFF_RSP1  = 3'd6;
  localparam logic [2:0] OFF_XTRA  = 3'd7;

  localparam logic [3:0] NIB_SLOW = 4'h4;
  localparam logic [3:0] NIB_FAST = 4'h5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_TAIL1, ST_TAIL2
  } eng_state_e;

  function automatic logic [2:0] tx_count(input logic [1:0] code);
    case (code)
      2'd0:    tx_count = 3'd1;
      2'd1:    tx_count = 3'd2;
      2'd2:    tx_count = 3'd4;
      default: tx_count = 3'd5;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] wire_frame(
    input logic [BYTE_W-1:0] op,
    input logic [BYTE_W-1:0] adr_a,
    input logic [BYTE_W-1:0] adr_b,
    input logic [BYTE_W-1:0] adr_c,
    input logic [BYTE_W-1:0] xtra,
    input logic [1:0]        code
  );
    case (code)
      2'd0:    wire_frame = {op, {(4*BYTE_W){1'b0}}};
      2'd1:    wire_frame = {op, xtra, {(3*BYTE_W){1'b0}}};
      2'd2:    wire_frame = {op, adr_a, adr_b, adr_c, {BYTE_W{1'b0}}};
      default: wire_frame = {op, adr_a, adr_b, adr_c, xtra};
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata,
  input  logic                 busy,
  input  logic [RX_W-1:0]      rx_bytes,
  output logic                 start,
  output logic                 start_fast,
  output logic [1:0]           start_code,
  output logic [1:0]           start_rcnt,
  output logic [FRAME_W-1:0]   frame
);
  logic [BYTE_W-1:0] op_q, adr_a_q, adr_b_q, adr_c_q, xtra_q;
  logic [BYTE_W-1:0] rsp [MAX_RX];
  logic              nib_ok;

  for (genvar g = 0; g < MAX_RX; g++) begin : g_rsp
    assign rsp[g] = rx_bytes[RX_W-1-g*BYTE_W -: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      adr_a_q <= '0;
      adr_b_q <= '0;
      adr_c_q <= '0;
      xtra_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_OP:    op_q    <= wdata;
        OFF_ADR_A: adr_a_q <= wdata;
        OFF_ADR_B: adr_b_q <= wdata;
        OFF_ADR_C: adr_c_q <= wdata;
        OFF_XTRA:  xtra_q  <= wdata;
        default:   ;
      endcase
    end
  end

  assign nib_ok     = (wdata[7:4] == NIB_SLOW) || (wdata[7:4] == NIB_FAST);
  assign start      = wr_en && (addr == OFF_CTRL) && !busy && nib_ok;
  assign start_fast = (wdata[7:4] == NIB_FAST);
  assign start_code = wdata[1:0];
  assign start_rcnt = wdata[3:2];
  assign frame      = wire_frame(op_q, adr_a_q, adr_b_q, adr_c_q, xtra_q, wdata[1:0]);

  always_comb begin
    case (addr)
      OFF_CTRL:  rdata = {busy, {(BYTE_W-1){1'b0}}};
      OFF_OP:    rdata = op_q;
      OFF_ADR_C: rdata = adr_c_q;
      OFF_ADR_B: rdata = adr_b_q;
      OFF_ADR_A: rdata = adr_a_q;
      OFF_RSP0:  rdata = rsp[0];
      OFF_RSP1:  rdata = rsp[1];
      default:   rdata = rsp[2];
    endcase
  end
endmodule

// File: rtl/spi_cmd_clkgen.sv
module spi_cmd_clkgen #(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CNT_W = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  if (SLOW_HALF == FAST_HALF) begin : g_single
    assign last = CNT_W'(SLOW_HALF - 1);
  end else begin : g_dual
    assign last = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);
  end

  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_fast,
  input  logic [1:0]           start_code,
  input  logic [1:0]           start_rcnt,
  input  logic [FRAME_W-1:0]   frame,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 busy,
  output logic                 fast,
  output logic                 sck,
  output logic                 cs_n,
  output logic                 mosi,
  output logic [RX_W-1:0]      rx_bytes
);
  localparam int IDX_W = $clog2(FRAME_W + RX_W + 1);
  localparam int SH_W  = $clog2(RX_W + 1);

  eng_state_e         state_q;
  logic [IDX_W-1:0]   idx_q, wbits_q, tbits_q, nidx, wb_n, rb_n;
  logic [1:0]         rcnt_q;
  logic [FRAME_W-1:0] tx_sr;
  logic [RX_W-1:0]    rx_sr, rx_q;
  logic               fast_q, sck_q, cs_n_q, mosi_q;
  logic [SH_W-1:0]    rx_sh;

  assign nidx  = idx_q + 1'b1;
  assign wb_n  = IDX_W'({tx_count(start_code), 3'b000});
  assign rb_n  = IDX_W'({start_rcnt, 3'b000});
  assign rx_sh = SH_W'((MAX_RX - int'(rcnt_q)) * BYTE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wbits_q <= '0;
      tbits_q <= '0;
      rcnt_q  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_q    <= '0;
      fast_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_LEAD;
            cs_n_q  <= 1'b0;
            sck_q   <= 1'b0;
            mosi_q  <= frame[FRAME_W-1];
            tx_sr   <= frame;
            wbits_q <= wb_n;
            tbits_q <= wb_n + rb_n;
            rcnt_q  <= start_rcnt;
            fast_q  <= start_fast;
            idx_q   <= '0;
            rx_sr   <= '0;
            rx_q    <= '0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state_q <= ST_HIGH;
            sck_q   <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            state_q <= ST_LOW;
            sck_q   <= 1'b0;
            mosi_q  <= (nidx < wbits_q) ? tx_sr[FRAME_W-2] : 1'b0;
            tx_sr   <= tx_sr << 1;
          end
        end
        ST_LOW: begin
          if (tick) begin
            if (nidx == tbits_q) begin
              state_q <= ST_TAIL1;
              cs_n_q  <= 1'b1;
              rx_q    <= rx_sr << rx_sh;
            end else begin
              state_q <= ST_HIGH;
              sck_q   <= 1'b1;
              idx_q   <= nidx;
              if (nidx >= wbits_q) rx_sr <= {rx_sr[RX_W-2:0], miso};
            end
          end
        end
        ST_TAIL1: if (tick) state_q <= ST_TAIL2;
        default:  if (tick) state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign fast     = fast_q;
  assign sck      = sck_q;
  assign cs_n     = cs_n_q;
  assign mosi     = mosi_q;
  assign rx_bytes = rx_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  import spi_cmd_pkg::*;

  logic               eng_busy, eng_fast, tick, start, start_fast;
  logic [1:0]         start_code, start_rcnt;
  logic [FRAME_W-1:0] frame;
  logic [RX_W-1:0]    rx_bytes;

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(eng_busy),
    .rx_bytes(rx_bytes), .start(start), .start_fast(start_fast),
    .start_code(start_code), .start_rcnt(start_rcnt), .frame(frame)
  );

  spi_cmd_clkgen #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .fast(eng_fast), .tick(tick)
  );

  spi_cmd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_fast(start_fast),
    .start_code(start_code), .start_rcnt(start_rcnt), .frame(frame),
    .tick(tick), .miso(spi_miso), .busy(eng_busy), .fast(eng_fast),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .rx_bytes(rx_bytes)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic       reg_wr,
  input logic [2:0] reg_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck && !mosi));

  a_r9_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  a_r8_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r9_cs_high_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cs_n) && $past(cs_n, 2) && !$past(sck)));

  a_r3_cs_falls_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $rose(busy));

  a_r10_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd0) |=> !$fell(cs_n));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .sck(spi_sck),
  .cs_n(spi_cs_n), .mosi(spi_mosi), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam int SLOW_HALF = 4;
  localparam int FAST_HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_cmd_engine #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  logic [3:0] exp_q[$];          // {busy, cs_n, sck, mosi} per cycle
  logic       last_busy = 1'b0;
  logic [7:0] m_op = 0, m_a2 = 0, m_a3 = 0, m_a4 = 0, m_x = 0;

  // flash slave model
  int          sbit = 0;
  int          swbits = 64;
  logic [23:0] resp = 24'd0;
  logic [63:0] s_cap = 64'd0;

  assign spi_miso = (sbit >= swbits && sbit < swbits + 24) ? resp[23 - (sbit - swbits)] : 1'b0;
  always @(posedge spi_sck) if (sbit < 64) s_cap[63 - sbit] <= spi_mosi;
  always @(negedge spi_sck) sbit = sbit + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle waveform comparison (R3 R4 R5 R7 R8 R9 R10 R11)
  always @(negedge clk) begin
    logic [3:0] e, a;
    if (rst_n && !done) begin
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 4'b0100;
      last_busy = e[3];
      a = {(reg_addr == 3'd0) ? reg_rdata[7] : e[3], spi_cs_n, spi_sck, spi_mosi};
      chk("R8/R9/R7 waveform {busy,cs_n,sck,mosi}", {60'd0, a}, {60'd0, e});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic push_cmd(input logic [7:0] c);
    int h, nb, wb, nbits;
    logic [7:0] by[$];
    logic [39:0] fr;
    h = (c[7:4] == 4'h5) ? FAST_HALF : SLOW_HALF;
    nb = (c[1:0] == 2'd0) ? 1 : (c[1:0] == 2'd1) ? 2 : (c[1:0] == 2'd2) ? 4 : 5;
    by.push_back(m_op);
    if (nb == 2) by.push_back(m_x);
    if (nb >= 4) begin by.push_back(m_a4); by.push_back(m_a3); by.push_back(m_a2); end
    if (nb == 5) by.push_back(m_x);
    fr = 40'd0;
    for (int k = 0; k < nb; k++) fr[39 - 8*k -: 8] = by[k];
    wb = nb * 8;
    nbits = wb + 8 * int'(c[3:2]);
    swbits = wb;
    sbit = 0;
    for (int k = 0; k < h; k++) exp_q.push_back({3'b100, fr[39]});
    for (int i = 0; i < nbits; i++) begin
      for (int k = 0; k < h; k++) exp_q.push_back({3'b101, (i < wb) ? fr[39 - i] : 1'b0});
      for (int k = 0; k < h; k++) exp_q.push_back({3'b100, (i + 1 < wb) ? fr[38 - i] : 1'b0});
    end
    for (int k = 0; k < 2*h; k++) exp_q.push_back(4'b1100);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 3'd0) begin
      if (!last_busy && (d[7:4] == 4'h4 || d[7:4] == 4'h5)) push_cmd(d);
    end else begin
      case (a)
        3'd1: m_op = d;
        3'd2: m_a2 = d;
        3'd3: m_a3 = d;
        3'd4: m_a4 = d;
        3'd7: m_x  = d;
        default: ;
      endcase
    end
    #1 reg_wr = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1 reg_addr = a;
    #1 v = reg_rdata;
    #1 reg_addr = 3'd0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_rx(input string tag, input logic [23:0] exp);
    logic [7:0] v0, v1, v2;
    rd(3'd5, v0); rd(3'd6, v1); rd(3'd7, v2);
    chk(tag, {40'd0, v0, v1, v2}, {40'd0, exp});
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset register value", {56'd0, v}, 64'd0);
    end
    chk("R1 reset pins {cs_n,sck,mosi}", {61'd0, spi_cs_n, spi_sck, spi_mosi}, 64'd4);

    // R2 readback
    wr(3'd1, 8'h9F); wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd7, 8'hA5);
    rd(3'd1, v); chk("R2 readback offset 1", {56'd0, v}, 64'h9F);
    rd(3'd2, v); chk("R2 readback offset 2", {56'd0, v}, 64'h11);
    rd(3'd3, v); chk("R2 readback offset 3", {56'd0, v}, 64'h22);
    rd(3'd4, v); chk("R2 readback offset 4", {56'd0, v}, 64'h33);

    // 5-byte write, 3 reads, fast (R4 R5 R6 R7)
    resp = 24'hC22017;
    wr(3'd0, 8'h5F);
    repeat (5) @(negedge clk);
    rd(3'd0, v); chk("R2 busy bit during command", {56'd0, v}, 64'h80);
    wait_idle();
    chk("R5 R4 five-byte wire order", {24'd0, s_cap[63:24]}, {24'd0, 40'h9F_33_22_11_A5});
    chk_rx("R6 three response bytes", 24'hC22017);

    // 1-byte write, 3 reads, slow
    resp = 24'hEF4018;
    wr(3'd0, 8'h4C);
    wait_idle();
    chk("R4 R5 one-byte opcode", {56'd0, s_cap[63:56]}, 64'h9F);
    chk_rx("R6 R7 slow three response bytes", 24'hEF4018);

    // 2-byte write, 1 read, slow
    wr(3'd1, 8'h01); wr(3'd7, 8'h02);
    resp = 24'h5A7788;
    wr(3'd0, 8'h45);
    wait_idle();
    chk("R5 two-byte order", {48'd0, s_cap[63:48]}, 64'h0102);
    chk_rx("R6 one response byte, rest zero", 24'h5A0000);

    // 4-byte write, 2 reads, fast
    wr(3'd1, 8'h03); wr(3'd4, 8'h01); wr(3'd3, 8'h02); wr(3'd2, 8'h03);
    resp = 24'h1234AB;
    wr(3'd0, 8'h5A);
    wait_idle();
    chk("R5 R4 four-byte order", {32'd0, s_cap[63:32]}, 64'h03010203);
    chk_rx("R6 two response bytes", 24'h123400);

    // 1-byte write, no reads
    wr(3'd1, 8'h06);
    wr(3'd0, 8'h50);
    wait_idle();
    chk_rx("R6 zero response bytes", 24'h000000);

    // R3 invalid nibbles
    wr(3'd0, 8'h6F); wr(3'd0, 8'h0F); wr(3'd0, 8'hC5);
    repeat (20) @(negedge clk);
    rd(3'd0, v); chk("R3 bad nibble leaves idle", {56'd0, v}, 64'h00);
    chk("R3 bad nibble cs_n high", {63'd0, spi_cs_n}, 64'd1);

    // R10 R11 writes during a command
    wr(3'd1, 8'h0B); wr(3'd4, 8'h44); wr(3'd3, 8'h55); wr(3'd2, 8'h66); wr(3'd7, 8'h77);
    resp = 24'hDEADBE;
    wr(3'd0, 8'h4F);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h5B);
    wr(3'd1, 8'hAA);
    wr(3'd4, 8'hBB);
    wait_idle();
    chk("R11 wire bytes unchanged by mid writes", {24'd0, s_cap[63:24]}, {24'd0, 40'h0B_44_55_66_77});
    chk_rx("R10 ignored control write keeps read count", 24'hDEADBE);
    rd(3'd1, v); chk("R11 mid-command write stored", {56'd0, v}, 64'hAA);
    rd(3'd4, v); chk("R11 mid-command address write stored", {56'd0, v}, 64'hBB);
    repeat (20) @(negedge clk);
    chk("R10 no second command", {63'd0, spi_cs_n}, 64'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule